// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small register file for board-level control. It sits on a plain 32-bit register bus that has an address, a write strobe with write data, and a read strobe with read data. Software uses it for several jobs. It reads two identity words that are fixed at build time. It drives a word of LED outputs and keeps two free configuration words. It keeps two flag words that are changed through separate set and clear addresses. It reads a reference counter that advances on an external 24 MHz tick enable. A handful of other addresses return constant status words.

A system reset is requested through a reset-level register, and that register is guarded by a lock. The lock opens only after one exact 16-bit key is written to the lock register. Any other value written there has bit 15 forced low, so the stored value can never equal the key by accident. An accepted reset-level write with bit 8 set sends a one-cycle request to an external reset generator.

The block has two resets. The bus reset returns the volatile state to zero. A separate power-on reset is the only thing that clears the non-volatile flags. A read of an address that maps to nothing returns zero and raises an error flag for one cycle.

Top module: `sys_regfile`

## Requirements
- R1: The bus reset clears these registers to 0: LEDs, lock, both configuration words, volatile flags, reset level and counter. After it, offset 0x00 reads the BOARD_ID parameter and offset 0x84 reads the PROC_ID parameter. Writes to either ID offset are ignored.
- R2: The LED word (0x08) and the configuration words (0x28 and 0x2C) are full 32-bit read/write registers.
- R3: A write to the lock register (0x20) stores 0xA05F when the data equals exactly 0x0000A05F. Any other data stores only its bits 14:0, with bit 15 read back as 0. A read of 0x20 returns the stored 16 bits, zero-extended.
- R4: The volatile flags register reads at 0x30. A write to 0x30 ORs the data into it. A write to 0x34 clears every bit that is 1 in the data.
- R5: The non-volatile flags register reads at 0x38. A write to 0x38 sets bits and a write to 0x3C clears bits. The bus reset leaves this register unchanged; only the power-on reset clears it.
- R6: A write to the reset-level register (0x40) is stored only while the lock holds 0xA05F. At any other time the write is ignored. Reads of 0x40 return the stored value.
- R7: An accepted reset-level write with data bit 8 set drives resetReq high for exactly the one cycle after the write. An accepted write with bit 8 clear drives no pulse.
- R8: The counter at 0x5C advances by one on each clock where tickEn is high. It is CNT_W bits wide, wraps modulo 2^CNT_W, and reads back zero-extended.
- R9: Fixed reads: 0x44 returns 1, 0x50 returns 0x1000 and 0x88 returns 0xFF000000. Reserved offsets 0x04, 0x0C–0x1C, 0x24, 0x48, 0x4C, 0x54, 0x58, 0x60–0x74, 0x80, 0x8C–0x9C and 0xC0–0xD0 read as 0 with no error. Writes to any of the fixed or reserved offsets change nothing.
- R10: A read of any other offset returns 0 and raises busErr for one cycle. This includes offsets that are not 4-byte aligned and the write-only addresses 0x34 and 0x3C. busErr stays low on reads of mapped offsets. Writes to unmapped offsets change nothing.
- R11: Read data is registered. busRdata shows the addressed value in the cycle after busRe is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low bus reset |
| porN | input | 1 | Asynchronous active-low power-on reset; the only reset for the non-volatile flags |
| tickEn | input | 1 | One-cycle enable at the 24 MHz reference rate |
| busAddr | input | 12 | Byte offset within the 4 KiB window |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle flag for a read of an unmapped offset |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
A fault in the lock register shows up on the next read of 0x20. It also shows one write later, when a reset-level write is accepted or refused against the model and a reset request that was or was not expected appears on resetReq a cycle after the write. A wrong decode entry shows up during the full-window read sweep, because it appears as a wrong word or a wrong busErr exactly one cycle after that address is read. Errors in the flag, counter or reset-domain logic show up at the first read-back after the set, clear, tick or reset that exposes them.

// File: rtl/sysregs_pkg.sv
package sysregs_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LOCK_W = 16;
  localparam int NUM_CFG = 2;

  localparam logic [ADDR_W-1:0] OFF_BOARD    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_LED      = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_LOCK     = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CFG0     = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_CFG1     = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_FLAG_SET = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_FLAG_CLR = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_NV_SET   = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_NV_CLR   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_RSTLVL   = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_ONE      = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_PAGE     = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_COUNT    = 12'h05C;
  localparam logic [ADDR_W-1:0] OFF_PROC     = 12'h084;
  localparam logic [ADDR_W-1:0] OFF_TOPBYTE  = 12'h088;

  localparam logic [DATA_W-1:0] VAL_ONE     = 32'h0000_0001;
  localparam logic [DATA_W-1:0] VAL_PAGE    = 32'h0000_1000;
  localparam logic [DATA_W-1:0] VAL_TOPBYTE = 32'hFF00_0000;

  localparam int RST_BIT = 8;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_BOARD, SEL_PROC, SEL_LED, SEL_LOCK, SEL_CFG0, SEL_CFG1,
    SEL_FLAGS, SEL_NV, SEL_RSTLVL, SEL_COUNT, SEL_ONE, SEL_PAGE, SEL_TOPBYTE
  } rdSel_e;

  typedef struct packed {
    logic               wrLed;
    logic               wrLock;
    logic [NUM_CFG-1:0] wrCfg;
    logic               setFlags;
    logic               clrFlags;
    logic               setNv;
    logic               clrNv;
    logic               wrRstLvl;
    logic               rdEn;
    rdSel_e             rdSel;
  } strobes_t;

  // Offsets that read as zero without raising the error flag.
  function automatic logic isReserved(input logic [ADDR_W-1:0] a);
    case (a)
      12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h024,
      12'h048, 12'h04C, 12'h054, 12'h058, 12'h060, 12'h064, 12'h068,
      12'h06C, 12'h070, 12'h074, 12'h080, 12'h08C, 12'h090, 12'h094,
      12'h098, 12'h09C, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sys_regfile_ctrl.sv
module sys_regfile_ctrl
  import sysregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              wdataRstBit,
  input  logic              busRe,
  input  logic              lockOpen,
  output strobes_t          st,
  output logic              rdErr,
  output logic              rstReq
);

  logic rdHit;

  // Address decode: write strobes and read select.
  always_comb begin
    st = '0;
    st.rdEn = busRe;
    st.rdSel = SEL_ZERO;
    rdHit = 1'b1;
    if (busWe) begin
      case (busAddr)
        OFF_LED:      st.wrLed = 1'b1;
        OFF_LOCK:     st.wrLock = 1'b1;
        OFF_CFG0:     st.wrCfg[0] = 1'b1;
        OFF_CFG1:     st.wrCfg[1] = 1'b1;
        OFF_FLAG_SET: st.setFlags = 1'b1;
        OFF_FLAG_CLR: st.clrFlags = 1'b1;
        OFF_NV_SET:   st.setNv = 1'b1;
        OFF_NV_CLR:   st.clrNv = 1'b1;
        OFF_RSTLVL:   st.wrRstLvl = lockOpen;
        default:      ;
      endcase
    end
    case (busAddr)
      OFF_BOARD:    st.rdSel = SEL_BOARD;
      OFF_PROC:     st.rdSel = SEL_PROC;
      OFF_LED:      st.rdSel = SEL_LED;
      OFF_LOCK:     st.rdSel = SEL_LOCK;
      OFF_CFG0:     st.rdSel = SEL_CFG0;
      OFF_CFG1:     st.rdSel = SEL_CFG1;
      OFF_FLAG_SET: st.rdSel = SEL_FLAGS;
      OFF_NV_SET:   st.rdSel = SEL_NV;
      OFF_RSTLVL:   st.rdSel = SEL_RSTLVL;
      OFF_COUNT:    st.rdSel = SEL_COUNT;
      OFF_ONE:      st.rdSel = SEL_ONE;
      OFF_PAGE:     st.rdSel = SEL_PAGE;
      OFF_TOPBYTE:  st.rdSel = SEL_TOPBYTE;
      default:      rdHit = isReserved(busAddr);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdErr  <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rdErr  <= busRe & ~rdHit;
      rstReq <= st.wrRstLvl & wdataRstBit;
    end
  end

endmodule

// File: rtl/sys_regfile_dp.sv
module sys_regfile_dp
  import sysregs_pkg::*;
#(
  parameter int                CNT_W      = 32,
  parameter logic [DATA_W-1:0] BOARD_ID   = '0,
  parameter logic [DATA_W-1:0] PROC_ID    = '0,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] busWdata,
  input  strobes_t          st,
  output logic [DATA_W-1:0] rdData,
  output logic              lockOpen
);

  localparam logic [LOCK_W-1:0] KEY_STORED = UNLOCK_KEY[LOCK_W-1:0];

  logic [DATA_W-1:0] ledReg;
  logic [LOCK_W-1:0] lockReg;
  logic [DATA_W-1:0] cfgReg [NUM_CFG];
  logic [DATA_W-1:0] flagReg;
  logic [DATA_W-1:0] nvReg;
  logic [DATA_W-1:0] rstLvlReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] rdMux;

  assign lockOpen = (lockReg == KEY_STORED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg    <= '0;
      lockReg   <= '0;
      flagReg   <= '0;
      rstLvlReg <= '0;
      cntReg    <= '0;
    end else begin
      if (st.wrLed) ledReg <= busWdata;
      if (st.wrLock) begin
        if (busWdata == UNLOCK_KEY) lockReg <= KEY_STORED;
        else lockReg <= {1'b0, busWdata[LOCK_W-2:0]};
      end
      if (st.setFlags) flagReg <= flagReg | busWdata;
      else if (st.clrFlags) flagReg <= flagReg & ~busWdata;
      if (st.wrRstLvl) rstLvlReg <= busWdata;
      if (tickEn) cntReg <= cntReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CFG; i++) cfgReg[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (st.wrCfg[i]) cfgReg[i] <= busWdata;
      end
    end
  end

  // Non-volatile flags live in the power-on domain only.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) nvReg <= '0;
    else if (st.setNv) nvReg <= nvReg | busWdata;
    else if (st.clrNv) nvReg <= nvReg & ~busWdata;
  end

  always_comb begin
    rdMux = '0;
    case (st.rdSel)
      SEL_BOARD:   rdMux = BOARD_ID;
      SEL_PROC:    rdMux = PROC_ID;
      SEL_LED:     rdMux = ledReg;
      SEL_LOCK:    rdMux[LOCK_W-1:0] = lockReg;
      SEL_CFG0:    rdMux = cfgReg[0];
      SEL_CFG1:    rdMux = cfgReg[1];
      SEL_FLAGS:   rdMux = flagReg;
      SEL_NV:      rdMux = nvReg;
      SEL_RSTLVL:  rdMux = rstLvlReg;
      SEL_COUNT:   rdMux[CNT_W-1:0] = cntReg;
      SEL_ONE:     rdMux = VAL_ONE;
      SEL_PAGE:    rdMux = VAL_PAGE;
      SEL_TOPBYTE: rdMux = VAL_TOPBYTE;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (st.rdEn) rdData <= rdMux;
  end

endmodule

// File: rtl/sys_regfile.sv
module sys_regfile
  import sysregs_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter logic [31:0] BOARD_ID   = 32'h0000_0000,
  parameter logic [31:0] PROC_ID    = 32'h0000_0000,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_A05F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic        tickEn,
  input  logic [11:0] busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  input  logic        busRe,
  output logic [31:0] busRdata,
  output logic        busErr,
  output logic        resetReq
);

  strobes_t st;
  logic     lockOpen;

  sys_regfile_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWe       (busWe),
    .wdataRstBit (busWdata[RST_BIT]),
    .busRe       (busRe),
    .lockOpen    (lockOpen),
    .st          (st),
    .rdErr       (busErr),
    .rstReq      (resetReq)
  );

  sys_regfile_dp #(
    .CNT_W      (CNT_W),
    .BOARD_ID   (BOARD_ID),
    .PROC_ID    (PROC_ID),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .porN     (porN),
    .tickEn   (tickEn),
    .busWdata (busWdata),
    .st       (st),
    .rdData   (busRdata),
    .lockOpen (lockOpen)
  );

endmodule

// File: rtl/sys_regfile_chk.sv
module sys_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic        busRe,
  input logic [31:0] busRdata,
  input logic        busErr,
  input logic        resetReq,
  input logic        lockOpen
);

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == 12'h020) |=> $stable(lockOpen));

  assert_key_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(lockOpen));

  assert_req_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busWe && busAddr == 12'h040 && busWdata[8]));

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busRdata == 32'h0);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busRe));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRe) |-> $stable(busRdata));

endmodule

bind sys_regfile sys_regfile_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRe    (busRe),
  .busRdata (busRdata),
  .busErr   (busErr),
  .resetReq (resetReq),
  .lockOpen (lockOpen)
);

// File: tb/tb_sys_regfile.sv
`timescale 1ns/1ps
module tb_sys_regfile;

  localparam int          CNT_W = 8;
  localparam logic [31:0] BOARD = 32'h1234_5678;
  localparam logic [31:0] PROC  = 32'h4100_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        porN = 1'b0;
  logic        tickEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        resetReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the register state
  logic [31:0] mLed, mLock, mCfg0, mCfg1, mFlags, mNv, mRst;
  int unsigned mCnt;

  always #5 clk = ~clk;

  sys_regfile #(.CNT_W(CNT_W), .BOARD_ID(BOARD), .PROC_ID(PROC)) dut (
    .clk(clk), .rstN(rstN), .porN(porN), .tickEn(tickEn),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRe(busRe),
    .busRdata(busRdata), .busErr(busErr), .resetReq(resetReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit isRsv(input logic [11:0] a);
    case (a)
      12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h024,
      12'h048, 12'h04C, 12'h054, 12'h058, 12'h060, 12'h064, 12'h068,
      12'h06C, 12'h070, 12'h074, 12'h080, 12'h08C, 12'h090, 12'h094,
      12'h098, 12'h09C, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // {err, data} expected from a read at offset a
  function automatic logic [32:0] expRead(input logic [11:0] a);
    case (a)
      12'h000: return {1'b0, BOARD};
      12'h084: return {1'b0, PROC};
      12'h008: return {1'b0, mLed};
      12'h020: return {1'b0, mLock};
      12'h028: return {1'b0, mCfg0};
      12'h02C: return {1'b0, mCfg1};
      12'h030: return {1'b0, mFlags};
      12'h038: return {1'b0, mNv};
      12'h040: return {1'b0, mRst};
      12'h05C: return {1'b0, 32'(mCnt % 256)};
      12'h044: return {1'b0, 32'h1};
      12'h050: return {1'b0, 32'h1000};
      12'h088: return {1'b0, 32'hFF00_0000};
      default: return isRsv(a) ? 33'h0 : {1'b1, 32'h0};
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    logic [32:0] e = expRead(a);
    if (e[32]) return "R10";
    if (isRsv(a) || a == 12'h044 || a == 12'h050 || a == 12'h088) return "R9";
    if (a == 12'h05C) return "R8";
    return "R1";
  endfunction

  function automatic void mWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h008: mLed = d;
      12'h020: mLock = (d == 32'h0000_A05F) ? d : {17'b0, d[14:0]};
      12'h028: mCfg0 = d;
      12'h02C: mCfg1 = d;
      12'h030: mFlags = mFlags | d;
      12'h034: mFlags = mFlags & ~d;
      12'h038: mNv = mNv | d;
      12'h03C: mNv = mNv & ~d;
      12'h040: if (mLock == 32'h0000_A05F) mRst = d;
      default: ;
    endcase
  endfunction

  function automatic void mBusReset();
    mLed = 0; mLock = 0; mCfg0 = 0; mCfg1 = 0; mFlags = 0; mRst = 0; mCnt = 0;
  endfunction

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, output logic req);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    req = resetReq;
    mWrite(a, d);
  endtask

  task automatic doRead(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata; e = busErr;
  endtask

  task automatic readChk(input logic [11:0] a, input string tag);
    logic [31:0] d;
    logic e;
    logic [32:0] x;
    x = expRead(a);
    doRead(a, d, e);
    chk(tag, d, x[31:0]);
    chk({tag, "_err"}, {31'b0, e}, {31'b0, x[32]});
  endtask

  task automatic sweepReads();
    for (int w = 0; w < 1024; w++) readChk(12'(w * 4), tagFor(12'(w * 4)));
    // misaligned offsets are unmapped
    readChk(12'h009, "R10");
    readChk(12'h022, "R10");
  endtask

  task automatic wrQuiet(input logic [11:0] a, input logic [31:0] d, input string tag);
    logic req;
    doWrite(a, d, req);
    chk(tag, {31'b0, req}, 32'h0);
  endtask

  task automatic busReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mBusReset();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      mCnt++;
    end
  endtask

  initial begin
    logic req;
    logic [31:0] d;
    logic e;
    mBusReset();
    mNv = 0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    rstN = 1'b1;

    // R1, R9, R10: whole window after reset
    sweepReads();

    // R9, R10, R6: writes to non-register offsets (and locked 0x40) are ignored
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w * 4);
      if (!(a inside {12'h008, 12'h020, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h038, 12'h03C}))
        wrQuiet(a, 32'hFFFF_FFFF, "R9");
    end
    sweepReads();

    // R2: plain read/write words
    wrQuiet(12'h008, 32'hA5A5_0F0F, "R2");
    wrQuiet(12'h028, 32'hDEAD_BEEF, "R2");
    wrQuiet(12'h02C, 32'h0123_4567, "R2");
    readChk(12'h008, "R2");
    readChk(12'h028, "R2");
    readChk(12'h02C, "R2");

    // R3: lock encoding
    wrQuiet(12'h020, 32'h1234_FFFF, "R3");
    readChk(12'h020, "R3");
    chk("R3", mLock, 32'h7FFF);
    wrQuiet(12'h020, 32'h0001_A05F, "R3");
    readChk(12'h020, "R3");
    chk("R3", mLock, 32'h205F);

    // R6: locked write ignored
    wrQuiet(12'h040, 32'h0000_01FF, "R6");
    readChk(12'h040, "R6");

    // R6, R7: unlocked write without bit 8
    wrQuiet(12'h020, 32'h0000_A05F, "R3");
    readChk(12'h020, "R3");
    wrQuiet(12'h040, 32'h0000_00FF, "R7");
    readChk(12'h040, "R6");
    chk("R6", mRst, 32'h0000_00FF);

    // R7: accepted write with bit 8 pulses for one cycle
    doWrite(12'h040, 32'h0000_0100, req);
    chk("R7", {31'b0, req}, 32'h1);
    @(negedge clk);
    chk("R7", {31'b0, resetReq}, 32'h0);
    readChk(12'h040, "R6");

    // R4: volatile flags
    wrQuiet(12'h030, 32'h0000_F0F0, "R4");
    wrQuiet(12'h030, 32'h0F00_0F00, "R4");
    readChk(12'h030, "R4");
    wrQuiet(12'h034, 32'h0300_3030, "R4");
    readChk(12'h030, "R4");
    chk("R4", mFlags, 32'h0C00_CFC0);
    readChk(12'h034, "R10");

    // R5: non-volatile flags survive bus reset
    wrQuiet(12'h038, 32'hDEAD_0000, "R5");
    wrQuiet(12'h038, 32'h0000_00FF, "R5");
    wrQuiet(12'h03C, 32'h0C00_000F, "R5");
    readChk(12'h038, "R5");
    chk("R5", mNv, 32'hD2AD_00F0);
    readChk(12'h03C, "R10");
    busReset();
    sweepReads();
    readChk(12'h038, "R5");

    // R8: counter, including wrap of the 8-bit build
    ticks(5);
    readChk(12'h05C, "R8");
    ticks(253);
    readChk(12'h05C, "R8");
    chk("R8", 32'(mCnt), 32'd258);

    // R11: data registered and held between reads
    readChk(12'h028, "R11");
    repeat (3) @(negedge clk);
    chk("R11", busRdata, mCfg0);
    doRead(12'h3FC, d, e);
    chk("R10", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R10", {31'b0, busErr}, 32'h0);
    chk("R11", busRdata, 32'h0);

    // R5: power-on reset clears the non-volatile flags
    @(negedge clk);
    porN = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    mBusReset();
    mNv = 0;
    readChk(12'h038, "R5");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule